// File: doc/BRIEF.md
# Two-Phase Request, Level-Latch Stage Controller

This block sequences one stage of a self-timed pipeline. Its handshake wires use transition signalling: every edge on a wire, rising or falling, is one event, and no wire ever returns to zero between transfers. The data latches it governs are ordinary level-sensitive latches. The controller drives a single enable line that keeps them transparent while idle and makes them opaque to hold a word.

A sender places data in front of the latch and toggles its request line. The controller closes the latch. In the next cycle it toggles the acknowledge back to the sender and the request onward to the receiver together. A busy flag stays high until the receiver toggles its acknowledge. The controller then reopens the latch for the next word. If the sender signals a new word while the stage is still busy, that event is remembered and served as soon as the latch has reopened.

The block is a clocked model. Both incoming handshake wires pass through a synchroniser of `SYNC_STAGES` flops. An event is found by comparing the synchronised level with its previous sample.

Top module: `hs_latch_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, latch_en is 1 (transparent), ack_out is 0, req_out is 0 and busy is 0. Both handshake inputs must be low when reset is released.
- R2: A request event is any change of req_in level. A rising edge and a falling edge have the same effect.
- R3: latch_en drops to 0 after the (SYNC_STAGES+1)-th rising clock edge that follows a req_in transition. With the default of 2 this is the third edge.
- R4: ack_out and req_out each toggle exactly one clock cycle after latch_en has dropped. They change together, and only while latch_en is 0.
- R5: A change of ack_in while the stage waits for the receiver sets latch_en back to 1 after the (SYNC_STAGES+1)-th rising edge, and clears busy in the same cycle.
- R6: Each transfer makes exactly one transition on ack_out and one on req_out. While the stage waits, both hold their level for any number of cycles.
- R7: A change of ack_in while the latch is open has no effect. latch_en, ack_out, req_out and busy keep their values, and the next request is handled normally.
- R8: busy is 1 from the cycle the latch closes until the cycle it reopens, and is never 1 while latch_en is 1.
- R9: A req_in event that arrives while busy is held pending and is not lost. After the receiver's acknowledge, latch_en is 1 for exactly one cycle, then closes again. ack_out and req_out toggle one cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 1 | Request from the sender; each transition announces a word |
| ack_out | output | 1 | Acknowledge to the sender; toggles once per captured word |
| req_out | output | 1 | Request to the receiver; toggles once per captured word |
| ack_in | input | 1 | Acknowledge from the receiver; each transition releases the stage |
| latch_en | output | 1 | Data latch enable: 1 transparent, 0 opaque |
| busy | output | 1 | High from capture until the receiver's acknowledge |

## Verification
With the default synchroniser depth, a toggle on req_in closes the latch after three rising edges and toggles both handshake outputs after four. A toggle on ack_in reopens the latch and drops busy after three rising edges. A pending request closes the latch one edge after it reopens and toggles the outputs one edge later. The bench changes inputs on falling edges and advances by counting falling edges. Each sample is therefore taken half a period after the edge on which the result is due. Some samples are placed one cycle before that edge, to show that the result has not arrived early.

// File: rtl/hs_latch_ctrl_pkg.sv
// Package: shared types for the stage controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package hs_latch_ctrl_pkg;

    // Controller phase: latch open, latch just closed, waiting for receiver.
    typedef enum logic [1:0] {
        PH_OPEN    = 2'd0,
        PH_CAPTURE = 2'd1,
        PH_WAIT    = 2'd2
    } phase_t;

    // Smallest legal synchroniser depth.
    localparam int unsigned MIN_SYNC = 2;

endpackage

// File: rtl/hs_edge_sync.sv
// Module: hs_edge_sync
// Brings one asynchronous handshake wire into the clock domain through a
// chain of STAGES flops. It flags an event for one cycle whenever the
// synchronised level differs from the previous sample.
// Assumes: STAGES >= 2, and the wire is low when reset is released.
module hs_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw wire through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    // Remember the last synchronised level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[TOP];
        end
    end

    // A transition in either direction is one event.
    always_comb begin
        evt = chain_q[TOP] ^ prev_q;
    end

endmodule

// File: rtl/hs_stage_fsm.sv
// Module: hs_stage_fsm
// Sequences one pipeline stage from synchronised request and acknowledge
// events. It closes the latch on a request, toggles both handshake outputs
// one cycle later, and reopens the latch on the receiver's acknowledge.
// A request seen while busy is kept in a one-deep pending flag.
// Assumes: the sender waits for ack_out before a further request, so at
// most one request can be outstanding beyond the one being held.
module hs_stage_fsm
    import hs_latch_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_evt,
    input  logic ack_evt,
    output logic latch_en,
    output logic ack_tgl,
    output logic req_tgl,
    output logic busy
);
    phase_t phase_q;
    phase_t phase_d;
    logic   pend_q;
    logic   pend_d;
    logic   ack_q;
    logic   req_q;
    logic   fire;

    // Next phase and pending-request bookkeeping.
    always_comb begin
        phase_d = phase_q;
        pend_d  = pend_q;
        fire    = 1'b0;
        unique case (phase_q)
            PH_OPEN: begin
                if (req_evt || pend_q) begin
                    phase_d = PH_CAPTURE;
                    pend_d  = 1'b0;
                end
            end
            PH_CAPTURE: begin
                phase_d = PH_WAIT;
                fire    = 1'b1;
                if (req_evt) begin
                    pend_d = 1'b1;
                end
            end
            PH_WAIT: begin
                if (ack_evt) begin
                    phase_d = PH_OPEN;
                end
                if (req_evt) begin
                    pend_d = 1'b1;
                end
            end
            default: begin
                phase_d = PH_OPEN;
                pend_d  = 1'b0;
            end
        endcase
    end

    // Phase and pending registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OPEN;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            pend_q  <= pend_d;
        end
    end

    // Handshake output levels: one toggle each per captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            req_q <= 1'b0;
        end else if (fire) begin
            ack_q <= ~ack_q;
            req_q <= ~req_q;
        end
    end

    // Decode the registered phase onto the outputs.
    always_comb begin
        latch_en = (phase_q == PH_OPEN);
        busy     = (phase_q != PH_OPEN);
        ack_tgl  = ack_q;
        req_tgl  = req_q;
    end

endmodule

// File: rtl/hs_latch_ctrl.sv
// Module: hs_latch_ctrl (top)
// Controller for one level-latch pipeline stage with transition-signalled
// handshakes. Both incoming wires are synchronised, then fed to the stage
// sequencer.
// Assumes: req_in and ack_in are low when reset is released; SYNC_STAGES >= 2.
module hs_latch_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic ack_out,
    output logic req_out,
    input  logic ack_in,
    output logic latch_en,
    output logic busy
);
    import hs_latch_ctrl_pkg::*;

    localparam int unsigned DEPTH = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

    logic [1:0] raw;
    logic [1:0] evt;

    // Gather the two incoming wires so one generate loop serves both.
    always_comb begin
        raw[0] = req_in;
        raw[1] = ack_in;
    end

    for (genvar g = 0; g < 2; g++) begin : g_sync
        hs_edge_sync #(.STAGES(DEPTH)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[g]),
            .evt   (evt[g])
        );
    end

    hs_stage_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_evt  (evt[0]),
        .ack_evt  (evt[1]),
        .latch_en (latch_en),
        .ack_tgl  (ack_out),
        .req_tgl  (req_out),
        .busy     (busy)
    );

endmodule

// File: rtl/hs_latch_ctrl_chk.sv
// Module: hs_latch_ctrl_chk
// Protocol checker bound to hs_latch_ctrl; it observes the ports only.
module hs_latch_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_out,
    input logic req_out,
    input logic latch_en,
    input logic busy
);
    // R4: the sender acknowledge toggles only with the latch held closed.
    p_ack_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out != $past(ack_out)) |-> (!$past(latch_en) && !latch_en));

    // R4: the onward request toggles in the same cycle as the acknowledge.
    p_req_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != $past(req_out)) |-> (ack_out != $past(ack_out)));

    // R6: at most one acknowledge transition, then it holds.
    p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out != $past(ack_out)) |=> $stable(ack_out));

    // R8: busy never coincides with an open latch.
    p_busy_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !latch_en);

    // R5: the latch reopens only out of a busy stage.
    p_reopen_from_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_en) |-> $past(busy));

endmodule

bind hs_latch_ctrl hs_latch_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_out  (ack_out),
    .req_out  (req_out),
    .latch_en (latch_en),
    .busy     (busy)
);

// File: tb/hs_latch_ctrl_test.sv
module hs_latch_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_in = 1'b0;
    logic ack_in = 1'b0;
    logic ack_out;
    logic req_out;
    logic latch_en;
    logic busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    hs_latch_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .ack_out  (ack_out),
        .req_out  (req_out),
        .ack_in   (ack_in),
        .latch_en (latch_en),
        .busy     (busy)
    );

    // Vector: {action[1:0] (0 none, 1 toggle req_in, 2 toggle ack_in),
    //          wait[2:0] falling edges, exp latch_en, exp ack_out/req_out, exp busy}
    localparam int NV = 8;
    localparam logic [7:0] VEC [NV] = '{
        {2'd1, 3'd2, 1'b1, 1'b0, 1'b0},  // R3: not yet closed after 2 edges
        {2'd0, 3'd1, 1'b0, 1'b0, 1'b1},  // R3: closed after 3rd edge
        {2'd0, 3'd1, 1'b0, 1'b1, 1'b1},  // R4: outputs toggle one cycle later
        {2'd0, 3'd5, 1'b0, 1'b1, 1'b1},  // R6: held while waiting
        {2'd2, 3'd2, 1'b0, 1'b1, 1'b1},  // R5: not yet reopened
        {2'd0, 3'd1, 1'b1, 1'b1, 1'b0},  // R5: reopened after 3rd edge
        {2'd1, 3'd4, 1'b0, 1'b0, 1'b1},  // R2: falling request edge works
        {2'd2, 3'd3, 1'b1, 1'b0, 1'b0}   // R5 again with falling ack_in
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_all(input string tag, input bit le, input bit ak, input bit bz);
        chk(latch_en == le, {tag, " latch_en"}, int'(latch_en), int'(le));
        chk(ack_out  == ak, {tag, " ack_out"},  int'(ack_out),  int'(ak));
        chk(req_out  == ak, {tag, " req_out"},  int'(req_out),  int'(ak));
        chk(busy     == bz, {tag, " busy"},     int'(busy),     int'(bz));
    endtask

    // Apply an action at the current falling edge, then advance n falling edges.
    task automatic step(input int act, input int n);
        if (act == 1) req_in = ~req_in;
        if (act == 2) ack_in = ~ack_in;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_all("R1 in reset", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R1 after release", 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(int'(VEC[i][7:6]), int'(VEC[i][5:3]));
            expect_all($sformatf("vector %0d (R2 R3 R4 R5 R6)", i),
                       VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R7: receiver acknowledge while open is ignored.
        step(2, 6);
        expect_all("R7 stray ack", 1'b1, 1'b0, 1'b0);
        step(1, 4);
        expect_all("R7 next request normal", 1'b0, 1'b1, 1'b1);

        // R9: request while busy is held and served after reopening.
        step(1, 6);
        expect_all("R9 held while busy", 1'b0, 1'b1, 1'b1);
        step(2, 3);
        expect_all("R9 reopen one cycle", 1'b1, 1'b1, 1'b0);
        step(0, 1);
        expect_all("R9 pending closes latch", 1'b0, 1'b1, 1'b1);
        step(0, 1);
        expect_all("R9 pending toggles outputs", 1'b0, 1'b0, 1'b1);
        step(2, 3);
        expect_all("R9 final reopen", 1'b1, 1'b0, 1'b0);

        // R1: reset in the middle of a transfer.
        step(1, 4);
        expect_all("R1 pre-reset busy", 1'b0, 1'b1, 1'b1);
        rst_n  = 1'b0;
        req_in = 1'b0;
        ack_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R1 mid-transfer reset", 1'b1, 1'b0, 1'b0);
        step(0, 5);
        expect_all("R1 stays idle", 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        summary();
    end

endmodule